// File: doc/BRIEF.md
# Packed Pixel Average and Squared-Difference Unit

This execution unit sits behind the operand read stage of a pixel-processing core. Each cycle it can accept two 32-bit register operands and a 2-bit operation code. Two cycles later it returns one 32-bit result that is written back to a register. It never touches memory.

Three of the four operations are rounding averages. The operands can be treated as one 32-bit value, as two independent 16-bit halves, or as four independent bytes. The fourth operation is a spatial-frequency measure. Byte i of operand A is paired with byte i of operand B, each byte difference is squared, and the four squares are summed. The unit is fully pipelined, so a new operation can enter on every cycle and results leave in issue order.

Top module: `pix_simd_unit`

## Requirements
- R1: While reset is held, `res_valid` and `op_ready` are low. After reset is released, `op_ready` rises within 3 clock cycles and stays high.
- R2: An operation is accepted on a rising edge where `op_valid` and `op_ready` are both high. `res_valid` is high on the second rising edge after acceptance, and it is high on no other edge.
- R3: Operations accepted on consecutive cycles produce results on consecutive cycles, in acceptance order, with no bubbles.
- R4: Code 2'b00 returns the unsigned average of the two 32-bit words, computed as (A+B+1)>>1 with a 33-bit sum, so all-ones averaged with all-ones gives all-ones.
- R5: Code 2'b01 averages bits [31:16] of A and B, and separately bits [15:0], each computed as (x+y+1)>>1. No carry passes from the low half into the high half.
- R6: Code 2'b10 averages each of the four byte lanes (bits [8i+7:8i]) independently, each computed as (x+y+1)>>1, rounding half up (1 and 2 give 2).
- R7: Code 2'b11 returns the sum over i=0..3 of (A byte i − B byte i)², zero-extended to 32 bits. Equal operands give 0, and the largest result is 0x0003F804.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Unit can accept an operation |
| op_code | input | 2 | 00 word avg, 01 halfword avg, 10 byte avg, 11 sum of squared byte differences |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| res_valid | output | 1 | Result valid strobe |
| res_data | output | 32 | Result word |

## Verification
The properties assume that `op_code`, `src_a` and `src_b` carry known values whenever `op_valid` is high. They also assume that the issuer never withholds results, since the unit has no output stall. They bound each lane average between the smaller and larger input lane, and they bound the squared-difference result. The stimulus drives all inputs to defined values from time zero and changes them only half a cycle away from the sampling edge. It mixes directed lane-boundary and carry cases with random operands, random idle gaps and an unbroken back-to-back burst.

// File: rtl/pix_simd_pkg.sv
package pix_simd_pkg;
  typedef enum logic [1:0] {
    OP_AVG_WORD = 2'b00,
    OP_AVG_HALF = 2'b01,
    OP_AVG_BYTE = 2'b10,
    OP_SQ_DIFF  = 2'b11
  } pix_op_e;
endpackage

// File: rtl/pix_lane_avg.sv
module pix_lane_avg #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W:0] sum_w;
  always_comb begin
    sum_w = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, 1'b1};
    y     = sum_w[W:1];
  end
endmodule

// File: rtl/pix_avg_unit.sv
module pix_avg_unit import pix_simd_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  pix_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int HALF_W = DATA_W / 2;
  localparam int N_BYTE = DATA_W / BYTE_W;

  logic [DATA_W-1:0] y_word, y_half, y_byte;

  pix_lane_avg #(.W(DATA_W)) u_word (.a(a), .b(b), .y(y_word));

  for (genvar g = 0; g < 2; g++) begin : g_half
    pix_lane_avg #(.W(HALF_W)) u_half (
      .a(a[g*HALF_W +: HALF_W]),
      .b(b[g*HALF_W +: HALF_W]),
      .y(y_half[g*HALF_W +: HALF_W])
    );
  end

  for (genvar g = 0; g < N_BYTE; g++) begin : g_byte
    pix_lane_avg #(.W(BYTE_W)) u_byte (
      .a(a[g*BYTE_W +: BYTE_W]),
      .b(b[g*BYTE_W +: BYTE_W]),
      .y(y_byte[g*BYTE_W +: BYTE_W])
    );
  end

  always_comb begin
    case (op)
      OP_AVG_HALF: y = y_half;
      OP_AVG_BYTE: y = y_byte;
      default:     y = y_word;
    endcase
  end
endmodule

// File: rtl/pix_sq_diff.sv
module pix_sq_diff #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] sq
);
  logic [W-1:0]   mag;
  logic [2*W-1:0] mag_w;
  always_comb begin
    mag   = (a > b) ? (a - b) : (b - a);
    mag_w = {{W{1'b0}}, mag};
    sq    = mag_w * mag_w;
  end
endmodule

// File: rtl/pix_sum_tree.sv
module pix_sum_tree #(
  parameter int N     = 4,
  parameter int SQ_W  = 16,
  parameter int OUT_W = 32
) (
  input  logic [N*SQ_W-1:0] terms,
  output logic [OUT_W-1:0]  total
);
  always_comb begin
    total = '0;
    for (int i = 0; i < N; i++) begin
      total = total + {{(OUT_W-SQ_W){1'b0}}, terms[i*SQ_W +: SQ_W]};
    end
  end
endmodule

// File: rtl/pix_simd_unit.sv
module pix_simd_unit import pix_simd_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_code,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data
);
  localparam int N_BYTE = DATA_W / BYTE_W;
  localparam int SQ_W   = 2 * BYTE_W;

  // reset release synchroniser
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];
  assign op_ready  = rst_int_n;

  // stage 1 datapath
  pix_op_e                op_in;
  logic [DATA_W-1:0]      avg_d;
  logic [N_BYTE*SQ_W-1:0] sq_d;
  logic                   accept;

  assign op_in  = pix_op_e'(op_code);
  assign accept = op_valid && op_ready;

  pix_avg_unit #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_avg (
    .op(op_in), .a(src_a), .b(src_b), .y(avg_d)
  );

  for (genvar g = 0; g < N_BYTE; g++) begin : g_sq
    pix_sq_diff #(.W(BYTE_W)) u_sq (
      .a(src_a[g*BYTE_W +: BYTE_W]),
      .b(src_b[g*BYTE_W +: BYTE_W]),
      .sq(sq_d[g*SQ_W +: SQ_W])
    );
  end

  logic                   s1_valid_q, s1_valid_d;
  pix_op_e                s1_op_q;
  logic [DATA_W-1:0]      s1_avg_q;
  logic [N_BYTE*SQ_W-1:0] s1_sq_q;

  always_comb s1_valid_d = accept;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) s1_valid_q <= 1'b0;
    else            s1_valid_q <= s1_valid_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_op_q  <= op_in;
      s1_avg_q <= avg_d;
      s1_sq_q  <= sq_d;
    end
  end

  // stage 2: reduction and select
  logic [DATA_W-1:0] ssd_sum, s2_data_d;

  pix_sum_tree #(.N(N_BYTE), .SQ_W(SQ_W), .OUT_W(DATA_W)) u_sum (
    .terms(s1_sq_q), .total(ssd_sum)
  );

  always_comb s2_data_d = (s1_op_q == OP_SQ_DIFF) ? ssd_sum : s1_avg_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) res_valid <= 1'b0;
    else            res_valid <= s1_valid_q;
  end

  always_ff @(posedge clk) begin
    if (s1_valid_q) res_data <= s2_data_d;
  end
endmodule

// File: rtl/pix_simd_chk.sv
module pix_simd_chk #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_ready,
  input logic [1:0]        op_code,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data
);
  localparam int HALF_W = DATA_W / 2;
  localparam int N_BYTE = DATA_W / BYTE_W;

  logic [1:0]        op_d1, op_d2;
  logic [DATA_W-1:0] a_d1, a_d2, b_d1, b_d2;
  always_ff @(posedge clk) begin
    op_d1 <= op_code; op_d2 <= op_d1;
    a_d1  <= src_a;   a_d2  <= a_d1;
    b_d1  <= src_b;   b_d2  <= b_d1;
  end

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_ready) |-> op_ready);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |-> ##2 res_valid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(op_valid && op_ready, 2));

  // R4
  word_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op_d2 == 2'b00) |->
      (res_data >= ((a_d2 < b_d2) ? a_d2 : b_d2)) &&
      (res_data <= ((a_d2 < b_d2) ? b_d2 : a_d2)));

  // R5
  for (genvar g = 0; g < 2; g++) begin : g_half_chk
    logic [HALF_W-1:0] ha, hb, hy;
    assign ha = a_d2[g*HALF_W +: HALF_W];
    assign hb = b_d2[g*HALF_W +: HALF_W];
    assign hy = res_data[g*HALF_W +: HALF_W];
    half_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && op_d2 == 2'b01) |->
        (hy >= ((ha < hb) ? ha : hb)) && (hy <= ((ha < hb) ? hb : ha)));
  end

  // R6
  for (genvar g = 0; g < N_BYTE; g++) begin : g_byte_chk
    logic [BYTE_W-1:0] ba, bb, by;
    assign ba = a_d2[g*BYTE_W +: BYTE_W];
    assign bb = b_d2[g*BYTE_W +: BYTE_W];
    assign by = res_data[g*BYTE_W +: BYTE_W];
    byte_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && op_d2 == 2'b10) |->
        (by >= ((ba < bb) ? ba : bb)) && (by <= ((ba < bb) ? bb : ba)));
  end

  // R7
  ssd_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op_d2 == 2'b11) |-> (res_data <= 32'h0003_F804));

  // R7
  ssd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op_d2 == 2'b11 && a_d2 == b_d2) |-> (res_data == '0));
endmodule

bind pix_simd_unit pix_simd_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_code(op_code), .src_a(src_a), .src_b(src_b),
  .res_valid(res_valid), .res_data(res_data)
);

// File: tb/tb_pix_simd_unit.sv
`timescale 1ns/1ps
module tb_pix_simd_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic        op_ready;
  logic [1:0]  op_code;
  logic [31:0] src_a, src_b;
  logic        res_valid;
  logic [31:0] res_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit chk_on = 1'b0;
  bit done   = 1'b0;
  bit burst  = 1'b0;

  int          q_due[$];
  logic [31:0] q_val[$];
  logic [1:0]  q_op[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pix_simd_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .src_a(src_a), .src_b(src_b),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [31:0] ref_model(input logic [1:0] op,
                                            input logic [31:0] a, b);
    logic [31:0] r;
    longint s;
    int d, acc;
    r = '0;
    case (op)
      2'b00: begin
        s = (longint'(a) + longint'(b) + 1) / 2;
        r = s[31:0];
      end
      2'b01: for (int i = 0; i < 2; i++) begin
        d = (int'(a[i*16 +: 16]) + int'(b[i*16 +: 16]) + 1) / 2;
        r[i*16 +: 16] = d[15:0];
      end
      2'b10: for (int i = 0; i < 4; i++) begin
        d = (int'(a[i*8 +: 8]) + int'(b[i*8 +: 8]) + 1) / 2;
        r[i*8 +: 8] = d[7:0];
      end
      default: begin
        acc = 0;
        for (int i = 0; i < 4; i++) begin
          d = int'(a[i*8 +: 8]) - int'(b[i*8 +: 8]);
          acc = acc + d * d;
        end
        r = acc;
      end
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [1:0] op);
    case (op)
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // compare against the reference queue once per cycle
  always @(negedge clk) begin
    if (chk_on) begin
      bit exp_v;
      exp_v = (q_due.size() > 0) && (q_due[0] == cyc);
      check(res_valid == exp_v, burst ? "R3" : "R2",
            {31'b0, res_valid}, {31'b0, exp_v});
      if (exp_v) begin
        check(res_data == q_val[0], req_of(q_op[0]), res_data, q_val[0]);
        void'(q_due.pop_front());
        void'(q_val.pop_front());
        void'(q_op.pop_front());
      end
    end
  end

  task automatic issue(input bit v, input logic [1:0] op, input logic [31:0] a, b);
    @(negedge clk);
    #1;
    op_valid = v;
    op_code  = op;
    src_a    = a;
    src_b    = b;
    if (v && op_ready) begin
      q_due.push_back(cyc + 2);
      q_val.push_back(ref_model(op, a, b));
      q_op.push_back(op);
    end
  endtask

  initial begin
    int waited;
    rst_n = 1'b0; op_valid = 1'b0; op_code = 2'b00; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(res_valid == 1'b0, "R1", {31'b0, res_valid}, 32'd0);
    check(op_ready == 1'b0, "R1", {31'b0, op_ready}, 32'd0);
    #1 rst_n = 1'b1;
    waited = 0;
    while (!op_ready && waited < 8) begin
      @(negedge clk);
      waited++;
    end
    // R1: ready within 3 cycles
    check(waited <= 3, "R1", waited, 32'd3);
    chk_on = 1'b1;

    // R4 directed: carry out of bit 31, rounding
    issue(1, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue(1, 2'b00, 32'h0000_0001, 32'h0000_0002);
    issue(0, 2'b00, 32'h0, 32'h0);
    issue(1, 2'b00, 32'h8000_0000, 32'h0000_0001);
    // R5 directed: low-half carry must not reach high half
    issue(1, 2'b01, 32'h0000_FFFF, 32'h0000_0001);
    issue(1, 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue(1, 2'b01, 32'h1234_0001, 32'h0002_0002);
    // R6 directed: byte lanes independent, round half up
    issue(1, 2'b10, 32'hFF01_FF01, 32'hFF02_0102);
    issue(1, 2'b10, 32'h00FF_00FF, 32'h0001_0001);
    // R7 directed: maximum, zero, lane pairing
    issue(1, 2'b11, 32'hFFFF_FFFF, 32'h0000_0000);
    issue(1, 2'b11, 32'hA5A5_5A5A, 32'hA5A5_5A5A);
    issue(1, 2'b11, 32'h0000_0010, 32'h1000_0000);
    issue(1, 2'b11, 32'h0102_0304, 32'h0403_0201);
    issue(0, 2'b00, 32'h0, 32'h0);

    // R2: random operations with idle gaps
    for (int i = 0; i < 400; i++) begin
      issue(($urandom % 3) != 0, 2'($urandom), $urandom, $urandom);
    end
    repeat (4) issue(0, 2'b00, 32'h0, 32'h0);

    // R3: unbroken back-to-back burst
    burst = 1'b1;
    for (int i = 0; i < 64; i++) begin
      issue(1, 2'($urandom), $urandom, $urandom);
    end
    repeat (4) issue(0, 2'b00, 32'h0, 32'h0);
    check(q_due.size() == 0, "R3", q_due.size(), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule